// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the delivery state for a small bank of interrupt sources. Each source is fixed at build time as either level-sensitive or message (event) type. Each source holds a destination server number, an 8-bit priority and a set of status flags. When a source becomes deliverable, the block offers its global interrupt number, server and priority to a downstream presenter. The global number is the source index plus a base offset.

The presenter reports back through three strobes. A reject strobe names a number that it declined. An end-of-interrupt strobe names a number whose handling has finished. A resend strobe asks every source to try again. A configuration write port sets one source's server and priority. Only one offer leaves the block per cycle. When several sources are eligible at once, they wait in per-source request flags and are offered lowest index first.

Every update takes effect at the clock edge. An offer caused by an input in cycle k is visible on the offer outputs in cycle k+1. It is removed in the following cycle, because an offer is considered taken in the cycle it is shown. Inside one cycle, events apply in this order: reject, end-of-interrupt, configuration, input, resend.

Top module: `irq_source_bank`

## Requirements
- R1: Source i is offered as number BASE+i (default BASE=16, 4 sources). A reject or end-of-interrupt strobe whose number lies outside BASE..BASE+NUM_SRC-1 changes no source.
- R2: After synchronous reset no offer is shown, every source has server 0 and priority 0xFF (masked), and all flags are clear. The level/message type of each source is not changed by reset (default: sources 2 and 3 level, 0 and 1 message).
- R3: A one-cycle event pulse on an unmasked message source produces one offer, in the next cycle, carrying the source's server and priority.
- R4: An event on a message source whose priority is 0xFF sets its masked-pending flag and produces no offer. A later configuration write with a priority other than 0xFF clears the flag and produces exactly one offer. A configuration write without the flag set produces none.
- R5: A reject on a message source sets its rejected flag without any offer. A resend then clears the flag and re-offers the source if it is unmasked, and a second resend offers nothing. End-of-interrupt has no effect on a message source.
- R6: A level source's asserted flag follows its input line. When the line changes or a configuration write occurs, and the source is unmasked, asserted and not yet sent, the sent flag is set and the source is offered once. While sent stays set, resend produces no further offer.
- R7: A reject on a level source clears its sent flag and produces no offer by itself. A following resend re-offers it if the line is still asserted.
- R8: End-of-interrupt on a level source clears its sent flag. If the line is still asserted and the source unmasked, the source is re-offered at once. If the line is low, nothing is offered.
- R9: At most one offer is shown per cycle. Pending requests are served lowest index first, and each pending request is offered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Per source: line level (level type) or one-cycle event pulse (message type) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index written |
| cfg_server | input | SRV_W | New server number |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| rej_valid | input | 1 | Reject strobe from presenter |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number completed |
| resend_all | input | 1 | Resend request for every source |
| offer_valid | output | 1 | An offer is shown this cycle |
| offer_num | output | NUM_W | Global number offered |
| offer_server | output | SRV_W | Server of the offered source |
| offer_prio | output | 8 | Priority of the offered source |

## Verification
The hardest states to reach are a level source that is still asserted but whose sent flag was cleared by a reject, and a message source that holds its masked-pending flag. Neither flag is visible at the ports. The bench reaches the first by raising the line, unmasking the source, rejecting it and then issuing a resend, and it checks that only the resend brings the offer back. It reaches the second by pulsing a masked source, for every message source in a priority sweep. A later unmasking write is the only thing that reveals the stored event.

// File: rtl/irq_bank_pkg.sv
// Package: shared priority width, the masking value and a small helper.
// Assumes 8-bit priorities, where the all-ones value means "masked".
package irq_bank_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

    // True when the priority lets the source be delivered.
    function automatic logic prio_open(input logic [PRIO_W-1:0] p);
        return p != PRIO_MASKED;
    endfunction
endpackage

// File: rtl/irq_msg_cell.sv
// Message-type source cell: holds server, priority, the masked-pending flag,
// the rejected flag and a request flag that waits for the offer arbiter.
// Assumes ev_i is a one-cycle pulse per event. Order in a cycle:
// reject, configuration, event, resend.
module irq_msg_cell
    import irq_bank_pkg::*;
#(
    parameter int SRV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_i,
    input  logic              cfg_hit_i,
    input  logic [SRV_W-1:0]  cfg_server_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic              rej_i,
    input  logic              resend_i,
    input  logic              grant_i,
    output logic              req_o,
    output logic [SRV_W-1:0]  server_o,
    output logic [PRIO_W-1:0] prio_o
);
    logic              pend_q, pend_n;
    logic              rejd_q, rejd_n;
    logic              req_q, req_n;
    logic [SRV_W-1:0]  srv_q;
    logic [PRIO_W-1:0] prio_q, prio_n;

    // Next-state of flags and request from this cycle's notifications.
    always_comb begin
        prio_n = cfg_hit_i ? cfg_prio_i : prio_q;
        rejd_n = rejd_q | rej_i;
        pend_n = pend_q;
        req_n  = req_q & ~grant_i;
        if (cfg_hit_i && pend_q && prio_open(prio_n)) begin
            pend_n = 1'b0;
            req_n  = 1'b1;
        end
        if (ev_i) begin
            if (prio_open(prio_n)) req_n  = 1'b1;
            else                   pend_n = 1'b1;
        end
        if (resend_i && rejd_n) begin
            rejd_n = 1'b0;
            if (prio_open(prio_n)) req_n = 1'b1;
        end
    end

    // State registers with synchronous reset to the masked, idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rejd_q <= 1'b0;
            req_q  <= 1'b0;
            srv_q  <= '0;
            prio_q <= PRIO_MASKED;
        end else begin
            pend_q <= pend_n;
            rejd_q <= rejd_n;
            req_q  <= req_n;
            prio_q <= prio_n;
            if (cfg_hit_i) srv_q <= cfg_server_i;
        end
    end

    assign req_o    = req_q;
    assign server_o = srv_q;
    assign prio_o   = prio_q;
endmodule

// File: rtl/irq_lvl_cell.sv
// Level-type source cell: tracks the asserted and sent flags. It runs the
// resend check on a line change, a configuration write, an end-of-interrupt
// or a resend. Assumes line_i is a synchronous level.
module irq_lvl_cell
    import irq_bank_pkg::*;
#(
    parameter int SRV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              cfg_hit_i,
    input  logic [SRV_W-1:0]  cfg_server_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic              rej_i,
    input  logic              eoi_i,
    input  logic              resend_i,
    input  logic              grant_i,
    output logic              req_o,
    output logic [SRV_W-1:0]  server_o,
    output logic [PRIO_W-1:0] prio_o
);
    logic              asrt_q;
    logic              sent_q, sent_n;
    logic              req_q, req_n;
    logic              check;
    logic [SRV_W-1:0]  srv_q;
    logic [PRIO_W-1:0] prio_q, prio_n;

    // Clear sent on reject/EOI, then run the resend check if triggered.
    always_comb begin
        prio_n = cfg_hit_i ? cfg_prio_i : prio_q;
        sent_n = sent_q & ~(rej_i | eoi_i);
        req_n  = req_q & ~grant_i;
        check  = (line_i != asrt_q) | cfg_hit_i | eoi_i | resend_i;
        if (check && line_i && prio_open(prio_n) && !sent_n) begin
            sent_n = 1'b1;
            req_n  = 1'b1;
        end
    end

    // State registers; the asserted flag follows the line each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asrt_q <= 1'b0;
            sent_q <= 1'b0;
            req_q  <= 1'b0;
            srv_q  <= '0;
            prio_q <= PRIO_MASKED;
        end else begin
            asrt_q <= line_i;
            sent_q <= sent_n;
            req_q  <= req_n;
            prio_q <= prio_n;
            if (cfg_hit_i) srv_q <= cfg_server_i;
        end
    end

    assign req_o    = req_q;
    assign server_o = srv_q;
    assign prio_o   = prio_q;
endmodule

// File: rtl/irq_offer_arb.sv
// Offer arbiter: picks the lowest-index pending request, grants it and
// forms the offer fields. Purely combinational; a grant retires the request.
module irq_offer_arb
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SRV_W   = 4,
    parameter int NUM_W   = 8,
    parameter int BASE    = 16
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][SRV_W-1:0]  server_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic [NUM_SRC-1:0]             grant_o,
    output logic                           valid_o,
    output logic [NUM_W-1:0]               num_o,
    output logic [SRV_W-1:0]               server_o,
    output logic [PRIO_W-1:0]              prio_o
);
    // Isolate the lowest set request bit.
    assign grant_o = req_i & (~req_i + NUM_SRC'(1));
    assign valid_o = |req_i;

    // Select the fields of the granted source.
    always_comb begin
        num_o    = '0;
        server_o = '0;
        prio_o   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) begin
                num_o    = NUM_W'(BASE + i);
                server_o = server_i[i];
                prio_o   = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_source_bank.sv
// Top: bank of NUM_SRC interrupt sources. LEVEL_MASK picks the type of
// each source and is not affected by reset. Reject and EOI numbers are
// matched against BASE+i; numbers outside the bank match nothing.
module irq_source_bank
    import irq_bank_pkg::*;
#(
    parameter int                 NUM_SRC    = 4,
    parameter int                 SRV_W      = 4,
    parameter int                 NUM_W      = 8,
    parameter int                 BASE       = 16,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 4'b1100,
    localparam int                IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [7:0]         cfg_prio,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_all,
    output logic               offer_valid,
    output logic [NUM_W-1:0]   offer_num,
    output logic [SRV_W-1:0]   offer_server,
    output logic [7:0]         offer_prio
);
    logic [NUM_SRC-1:0]             req_vec;
    logic [NUM_SRC-1:0]             grant_vec;
    logic [NUM_SRC-1:0][SRV_W-1:0]  srv_vec;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;

    // One cell per source, of the type chosen by LEVEL_MASK.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (LEVEL_MASK[i]) begin : g_lvl
            irq_lvl_cell #(.SRV_W(SRV_W)) cell_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .line_i       (src_in[i]),
                .cfg_hit_i    (cfg_we && (cfg_idx == IDX_W'(i))),
                .cfg_server_i (cfg_server),
                .cfg_prio_i   (cfg_prio),
                .rej_i        (rej_valid && (rej_num == NUM_W'(BASE + i))),
                .eoi_i        (eoi_valid && (eoi_num == NUM_W'(BASE + i))),
                .resend_i     (resend_all),
                .grant_i      (grant_vec[i]),
                .req_o        (req_vec[i]),
                .server_o     (srv_vec[i]),
                .prio_o       (prio_vec[i])
            );
        end else begin : g_msg
            irq_msg_cell #(.SRV_W(SRV_W)) cell_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .ev_i         (src_in[i]),
                .cfg_hit_i    (cfg_we && (cfg_idx == IDX_W'(i))),
                .cfg_server_i (cfg_server),
                .cfg_prio_i   (cfg_prio),
                .rej_i        (rej_valid && (rej_num == NUM_W'(BASE + i))),
                .resend_i     (resend_all),
                .grant_i      (grant_vec[i]),
                .req_o        (req_vec[i]),
                .server_o     (srv_vec[i]),
                .prio_o       (prio_vec[i])
            );
        end
    end

    irq_offer_arb #(
        .NUM_SRC (NUM_SRC),
        .SRV_W   (SRV_W),
        .NUM_W   (NUM_W),
        .BASE    (BASE)
    ) arb_i (
        .req_i    (req_vec),
        .server_i (srv_vec),
        .prio_i   (prio_vec),
        .grant_o  (grant_vec),
        .valid_o  (offer_valid),
        .num_o    (offer_num),
        .server_o (offer_server),
        .prio_o   (offer_prio)
    );
endmodule

// File: rtl/irq_source_bank_chk.sv
// Checker for irq_source_bank: offer numbering, arbiter grants against the
// request vector, and the state right after reset. Attached by bind below.
module irq_source_bank_chk #(
    parameter int NUM_SRC = 4,
    parameter int NUM_W   = 8,
    parameter int BASE    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               offer_valid,
    input logic [NUM_W-1:0]   offer_num,
    input logic [NUM_SRC-1:0] req,
    input logic [NUM_SRC-1:0] grant
);
    // R1
    offer_num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_num >= NUM_W'(BASE)) && (offer_num < NUM_W'(BASE + NUM_SRC)));

    // R9
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> $onehot(grant));

    // R9
    grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R2
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!offer_valid && (req == '0)));
endmodule

bind irq_source_bank irq_source_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_W   (NUM_W),
    .BASE    (BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .offer_valid (offer_valid),
    .offer_num   (offer_num),
    .req         (req_vec),
    .grant       (grant_vec)
);

// File: tb/irq_source_bank_tb_top.sv
// Bench for irq_source_bank with default parameters: sources 0,1 message,
// sources 2,3 level, BASE 16. Drives on the falling edge, samples there.
module irq_source_bank_tb_top;
    localparam int BASE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_in = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [3:0] cfg_server = '0;
    logic [7:0] cfg_prio = '0;
    logic       rej_valid = 1'b0;
    logic [7:0] rej_num = '0;
    logic       eoi_valid = 1'b0;
    logic [7:0] eoi_num = '0;
    logic       resend_all = 1'b0;
    logic       offer_valid;
    logic [7:0] offer_num;
    logic [3:0] offer_server;
    logic [7:0] offer_prio;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_source_bank dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_all(resend_all),
        .offer_valid(offer_valid), .offer_num(offer_num),
        .offer_server(offer_server), .offer_prio(offer_prio)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_offer(input logic v, input int num, input int srv,
                                input int prio, input string tag);
        logic ok;
        checks++;
        if (v) ok = offer_valid && (offer_num == 8'(num)) &&
                    (offer_server == 4'(srv)) && (offer_prio == 8'(prio));
        else   ok = !offer_valid;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got v=%0d num=%0d srv=%0d prio=%0h, want v=%0d num=%0d srv=%0d prio=%0h",
                     tag, offer_valid, offer_num, offer_server, offer_prio, v, num, srv, prio);
        end
    endtask

    task automatic cfg(input int idx, input int srv, input int prio);
        cfg_idx = 2'(idx); cfg_server = 4'(srv); cfg_prio = 8'(prio); cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int idx);
        src_in[idx] = 1'b1;
        step();
        src_in[idx] = 1'b0;
    endtask

    task automatic reject(input int num);
        rej_num = 8'(num); rej_valid = 1'b1;
        step();
        rej_valid = 1'b0;
    endtask

    task automatic eoi(input int num);
        eoi_num = 8'(num); eoi_valid = 1'b1;
        step();
        eoi_valid = 1'b0;
    endtask

    task automatic resend();
        resend_all = 1'b1;
        step();
        resend_all = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got running, want finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int plist[4] = '{8'h00, 8'h40, 8'hFE, 8'hFF};
        @(negedge clk);
        step();
        rst_n = 1'b1;
        step();
        expect_offer(0, 0, 0, 0, "R2 reset idle");

        // R4: masked event held, released by unmasking write.
        pulse(0);
        expect_offer(0, 0, 0, 0, "R4 masked event no offer");
        cfg(0, 3, 5);
        expect_offer(1, BASE, 3, 5, "R4 unmask releases pending");
        step();
        expect_offer(0, 0, 0, 0, "R9 offered once");
        cfg(0, 3, 5);
        expect_offer(0, 0, 0, 0, "R4 write without pending");

        // R3
        pulse(0);
        expect_offer(1, BASE, 3, 5, "R3 unmasked event");
        step();

        // R5
        reject(BASE);
        expect_offer(0, 0, 0, 0, "R5 reject no offer");
        eoi(BASE);
        expect_offer(0, 0, 0, 0, "R5 eoi ignored on message");
        resend();
        expect_offer(1, BASE, 3, 5, "R5 resend after reject");
        step();
        resend();
        expect_offer(0, 0, 0, 0, "R5 rejected flag cleared");

        // R1: out-of-range numbers touch nothing.
        reject(BASE + 4);
        reject(BASE - 16);
        resend();
        expect_offer(0, 0, 0, 0, "R1 out-of-range reject");

        // R6, R7, R8 on level source 2.
        src_in[2] = 1'b1;
        step();
        expect_offer(0, 0, 0, 0, "R6 masked level no offer");
        cfg(2, 1, 4);
        expect_offer(1, BASE + 2, 1, 4, "R6 unmask asserted level");
        step();
        resend();
        expect_offer(0, 0, 0, 0, "R6 no resend while sent");
        eoi(BASE + 2);
        expect_offer(1, BASE + 2, 1, 4, "R8 eoi re-offers asserted");
        step();
        reject(BASE + 2);
        expect_offer(0, 0, 0, 0, "R7 reject no offer");
        resend();
        expect_offer(1, BASE + 2, 1, 4, "R7 resend after reject");
        step();
        src_in[2] = 1'b0;
        step();
        eoi(BASE + 2);
        expect_offer(0, 0, 0, 0, "R8 eoi with line low");
        src_in[2] = 1'b1;
        step();
        expect_offer(1, BASE + 2, 1, 4, "R6 line rise offers");
        step();

        // R9: simultaneous events offered lowest index first.
        cfg(1, 2, 9);
        expect_offer(0, 0, 0, 0, "R4 write no pending src1");
        src_in[0] = 1'b1; src_in[1] = 1'b1;
        step();
        src_in[0] = 1'b0; src_in[1] = 1'b0;
        expect_offer(1, BASE, 3, 5, "R9 lowest first");
        step();
        expect_offer(1, BASE + 1, 2, 9, "R9 second next cycle");
        step();
        expect_offer(0, 0, 0, 0, "R9 drained");

        // Sweep message sources over priorities (R3, R4).
        for (int i = 0; i < 2; i++) begin
            for (int k = 0; k < 4; k++) begin
                int srv;
                srv = (i * 4 + k) % 16;
                cfg(i, srv, plist[k]);
                expect_offer(0, 0, 0, 0, "R4 sweep config");
                pulse(i);
                if (plist[k] != 8'hFF) begin
                    expect_offer(1, BASE + i, srv, plist[k], "R3 sweep event");
                    step();
                end else begin
                    expect_offer(0, 0, 0, 0, "R4 sweep masked event");
                    cfg(i, srv, 8'h10);
                    expect_offer(1, BASE + i, srv, 8'h10, "R4 sweep release");
                    step();
                end
            end
        end

        // R2: reset mid-run restores masking, keeps source types.
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        expect_offer(0, 0, 0, 0, "R2 idle after reset");
        pulse(0);
        expect_offer(0, 0, 0, 0, "R2 priority masked after reset");
        cfg(2, 5, 3);
        expect_offer(1, BASE + 2, 5, 3, "R2 level type kept");
        step();
        cfg(0, 7, 1);
        expect_offer(1, BASE, 7, 1, "R2 message type kept");
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule